// File: doc/BRIEF.md
# Prioritised Interrupt Pending and Arbitration Core

This block is the decision core of a nested interrupt controller. It serves a parameterised set of external request lines. For each line it keeps four pieces of state: an enable bit, a pending bit, an active bit and a priority value. It then tells the processor which request should be taken next. Software reaches this state through a small register window. The window has separate write-one-to-set and write-one-to-clear addresses, byte-lane priority words and a software trigger. Two inputs can block requests: a global mask bit and a base-priority threshold.

The core latches a rising edge on a request line into its pending bit. The pending bit then holds even if the line drops. On each cycle the core picks the best enabled, unmasked, pending and not-yet-active request. It offers that request only when it would preempt the level that is currently running. When the processor acknowledges, the request moves from pending to active and its level goes onto a nesting stack. A return strobe pops the most recently entered level.

Top module: `irq_arbiter_core`

## Requirements
- R1: Enable state has a set address (offset 0x00) and a clear address (offset 0x04). Writing 1 to a bit at the set address sets it, and writing 1 at the clear address clears it. Writing 0 changes nothing. Both addresses read back the enable bits in bits [N-1:0]. All state resets to zero.
- R2: Pending state has a set address (0x08) and a clear address (0x04 + 0x08 = 0x0C) with the same write-one rules. Both addresses read back the pending bits. A pending bit cleared before service cancels that interrupt.
- R3: A 0-to-1 transition on a request line sets its pending bit, and the bit stays set after the line falls. Any number of transitions before service leave a single pending request.
- R4: Acknowledging the offered request clears its pending bit and sets its active bit. The active bits read at offset 0x10. A return clears the active bit of the most recently entered interrupt. A return with nothing active has no effect.
- R5: A new rising edge during an interrupt's own handler sets its pending bit again. A request line still high when its handler returns also sets pending again, so the interrupt is entered once more.
- R6: The priority of interrupt n lives in byte lane n%4 of the word at offset 0x20 + 4*(n/4), and is written only when that lane's byte strobe is set. Only the top 3 bits of each byte are stored, and the low 5 bits read as zero.
- R7: The offered request is the pending, enabled, non-active request with the lowest priority value. Among equal values, the lowest interrupt number wins. irq_prio shows its priority byte.
- R8: A request is offered only if its priority value is strictly lower than that of the innermost active interrupt. With nothing active, any priority may be offered. Nested activations return in last-in, first-out order.
- R9: While global_mask is 1, no request is offered. Pending state is kept and is offered once the mask clears.
- R10: When base_mask is nonzero, a request whose priority byte is greater than or equal to base_mask is not offered. A zero base_mask blocks nothing.
- R11: Writing an interrupt number to offset 0x40 sets that interrupt's pending bit. A number of N or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_IRQ | Request lines, one per interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte strobes, used for the priority words |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| global_mask | input | 1 | Blocks every request while 1 |
| base_mask | input | 8 | Priority threshold, 0 disables it |
| irq_valid | output | 1 | A request is offered for preemption |
| irq_id | output | clog2(NUM_IRQ) | Number of the offered request |
| irq_prio | output | 8 | Priority byte of the offered request |
| irq_ack | input | 1 | Processor starts the offered handler |
| irq_ret | input | 1 | Processor returns from the innermost handler |

## Verification
The assertions take for granted that the processor acknowledges only while irq_valid is high. They also take for granted that it never raises irq_ack and irq_ret in the same cycle. Under those conditions the count of active bits always equals the nesting depth. The bench drives each strobe as a single-cycle pulse, and only at points where it has already checked the offered request. It also changes priorities only while no interrupt is active, so every stacked level matches the priority that was written.

// File: rtl/irq_arbiter_core.sv
module irq_arbiter_core #(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_req,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  input  logic [3:0]                 reg_be,
  output logic [31:0]                reg_rdata,
  input  logic                       global_mask,
  input  logic [7:0]                 base_mask,
  output logic                       irq_valid,
  output logic [$clog2(NUM_IRQ)-1:0] irq_id,
  output logic [7:0]                 irq_prio,
  input  logic                       irq_ack,
  input  logic                       irq_ret
);
  localparam int IDW      = $clog2(NUM_IRQ);
  localparam int SPW      = $clog2(NUM_IRQ + 1);
  localparam int LOW      = 8 - PRIO_BITS;
  localparam int OFF_ENS  = 'h00;
  localparam int OFF_ENC  = 'h04;
  localparam int OFF_PSET = 'h08;
  localparam int OFF_PCLR = 'h0C;
  localparam int OFF_ACT  = 'h10;
  localparam int OFF_PRIO = 'h20;
  localparam int OFF_TRIG = 'h40;

  logic [NUM_IRQ-1:0]   en_q, pend_q, act_q, req_q;
  logic [PRIO_BITS-1:0] prio_q [NUM_IRQ];
  logic [IDW-1:0]       stk_id [NUM_IRQ];
  logic [PRIO_BITS-1:0] stk_pr [NUM_IRQ];
  logic [SPW-1:0]       sp_q;

  wire hit_ens  = reg_addr == ADDR_W'(OFF_ENS);
  wire hit_enc  = reg_addr == ADDR_W'(OFF_ENC);
  wire hit_pset = reg_addr == ADDR_W'(OFF_PSET);
  wire hit_pclr = reg_addr == ADDR_W'(OFF_PCLR);
  wire hit_act  = reg_addr == ADDR_W'(OFF_ACT);
  wire hit_trig = reg_addr == ADDR_W'(OFF_TRIG);

  logic [NUM_IRQ-1:0] wbits;
  assign wbits = reg_wdata[NUM_IRQ-1:0];

  logic [IDW-1:0] top_idx;
  logic [IDW-1:0] top_id;
  logic [PRIO_BITS:0] cur_lvl;
  assign top_idx = IDW'(sp_q - 1'b1);
  assign top_id  = stk_id[top_idx];
  assign cur_lvl = (sp_q == '0) ? {1'b1, {PRIO_BITS{1'b0}}} : {1'b0, stk_pr[top_idx]};

  logic [NUM_IRQ-1:0] blocked, cand;
  always_comb begin
    for (int n = 0; n < NUM_IRQ; n++)
      blocked[n] = (base_mask != 8'd0) && ({prio_q[n], {LOW{1'b0}}} >= base_mask);
  end
  assign cand = pend_q & en_q & ~act_q & ~blocked;

  logic                 found;
  logic [IDW-1:0]       best_id;
  logic [PRIO_BITS-1:0] best_p;
  always_comb begin
    found   = 1'b0;
    best_id = '0;
    best_p  = '1;
    for (int n = 0; n < NUM_IRQ; n++) begin
      if (cand[n] && (!found || prio_q[n] < best_p)) begin
        found   = 1'b1;
        best_id = IDW'(n);
        best_p  = prio_q[n];
      end
    end
  end

  assign irq_valid = found && !global_mask && ({1'b0, best_p} < cur_lvl);
  assign irq_id    = best_id;
  assign irq_prio  = {best_p, {LOW{1'b0}}};

  wire take = irq_ack && irq_valid;
  wire give = irq_ret && !take && (sp_q != '0);

  logic [NUM_IRQ-1:0] take_oh, give_oh, trig_oh, rise;
  assign take_oh = take ? (NUM_IRQ'(1) << irq_id) : '0;
  assign give_oh = give ? (NUM_IRQ'(1) << top_id) : '0;
  assign trig_oh = (reg_wr && hit_trig && reg_wdata < 32'(NUM_IRQ))
                   ? (NUM_IRQ'(1) << reg_wdata[IDW-1:0]) : '0;
  assign rise    = irq_req & ~req_q;

  logic [NUM_IRQ-1:0] pend_set, pend_clr, en_set, en_clr;
  assign pend_set = rise | trig_oh | (give_oh & irq_req) | ((reg_wr && hit_pset) ? wbits : '0);
  assign pend_clr = take_oh | ((reg_wr && hit_pclr) ? wbits : '0);
  assign en_set   = (reg_wr && hit_ens) ? wbits : '0;
  assign en_clr   = (reg_wr && hit_enc) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      req_q  <= '0;
      sp_q   <= '0;
      for (int n = 0; n < NUM_IRQ; n++) begin
        prio_q[n] <= '0;
        stk_id[n] <= '0;
        stk_pr[n] <= '0;
      end
    end else begin
      en_q   <= (en_q & ~en_clr) | en_set;
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      act_q  <= (act_q & ~give_oh) | take_oh;
      req_q  <= irq_req;
      for (int n = 0; n < NUM_IRQ; n++)
        if (reg_wr && reg_be[n % 4] && reg_addr == ADDR_W'(OFF_PRIO + 4 * (n / 4)))
          prio_q[n] <= reg_wdata[8 * (n % 4) + 7 -: PRIO_BITS];
      if (take) begin
        stk_id[IDW'(sp_q)] <= irq_id;
        stk_pr[IDW'(sp_q)] <= best_p;
        sp_q <= sp_q + 1'b1;
      end else if (give) begin
        sp_q <= sp_q - 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_ens || hit_enc)   reg_rdata[NUM_IRQ-1:0] = en_q;
    if (hit_pset || hit_pclr) reg_rdata[NUM_IRQ-1:0] = pend_q;
    if (hit_act)              reg_rdata[NUM_IRQ-1:0] = act_q;
    for (int n = 0; n < NUM_IRQ; n++)
      if (reg_addr == ADDR_W'(OFF_PRIO + 4 * (n / 4)))
        reg_rdata[8 * (n % 4) + 7 -: PRIO_BITS] = prio_q[n];
  end
endmodule

module irq_arbiter_core_chk #(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       irq_valid,
  input logic [$clog2(NUM_IRQ)-1:0] irq_id,
  input logic [7:0]                 irq_prio,
  input logic                       irq_ack,
  input logic                       irq_ret,
  input logic                       global_mask,
  input logic [7:0]                 base_mask,
  input logic [NUM_IRQ-1:0]         en_q,
  input logic [NUM_IRQ-1:0]         pend_q,
  input logic [NUM_IRQ-1:0]         act_q,
  input logic [$clog2(NUM_IRQ+1)-1:0] sp_q
);
  AST_OFFER_IS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (en_q[irq_id] && pend_q[irq_id] && !act_q[irq_id])); // R7
  AST_GLOBAL_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    global_mask |-> !irq_valid); // R9
  AST_BASE_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && base_mask != 8'd0) |-> (irq_prio < base_mask)); // R10
  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_valid) |=> act_q[$past(irq_id)]); // R4
  AST_DEPTH_MATCHES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_q) == int'(sp_q)); // R8
  AST_RETURN_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack && act_q != '0) |=> ($countones(act_q) + 1 == $past($countones(act_q)))); // R8
endmodule

bind irq_arbiter_core irq_arbiter_core_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio),
  .irq_ack(irq_ack), .irq_ret(irq_ret), .global_mask(global_mask), .base_mask(base_mask),
  .en_q(en_q), .pend_q(pend_q), .act_q(act_q), .sp_q(sp_q)
);

// File: tb/irq_arbiter_core_test.sv
module irq_arbiter_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_rdata;
  logic global_mask = 1'b0;
  logic [7:0] base_mask = '0;
  logic irq_valid;
  logic [2:0] irq_id;
  logic [7:0] irq_prio;
  logic irq_ack = 1'b0;
  logic irq_ret = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_arbiter_core uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata), .global_mask(global_mask),
    .base_mask(base_mask), .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio),
    .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(posedge clk);
    #1 reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(posedge clk);
    #1 irq_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic ret();
    irq_ret = 1'b1;
    @(posedge clk);
    #1 irq_ret = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int i);
    irq_req[i] = 1'b1; tick();
    irq_req[i] = 1'b0; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] exp_p [N];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rdchk("R1 reset enable", 8'h00, 0);
    rdchk("R2 reset pending", 8'h08, 0);
    rdchk("R4 reset active", 8'h10, 0);
    rdchk("R6 reset prio", 8'h20, 0);
    chk("R7 reset valid", {31'd0, irq_valid}, 0);

    // R1 enable set/clear
    wr(8'h00, 32'h0F);
    rdchk("R1 set read", 8'h00, 32'h0F);
    rdchk("R1 clear addr read", 8'h04, 32'h0F);
    wr(8'h00, 32'h00);
    rdchk("R1 zero write no effect", 8'h00, 32'h0F);
    wr(8'h04, 32'h05);
    rdchk("R1 clear bits", 8'h00, 32'h0A);
    wr(8'h04, 32'hFF);
    rdchk("R1 clear all", 8'h04, 32'h00);

    // R6 priority byte lanes
    for (int n = 0; n < N; n++) exp_p[n] = 8'h00;
    for (int n = 0; n < N; n++) begin
      for (int j = 0; j < 3; j++) begin
        logic [7:0] v;
        logic [31:0] ew;
        v = (j == 0) ? 8'hFF : (j == 1) ? 8'hA5 : 8'h3C;
        wr(8'h20 + 8'(4 * (n / 4)), {4{v}}, 4'b0001 << (n % 4));
        exp_p[n] = v & 8'hE0;
        ew = '0;
        for (int b = 0; b < 4; b++) ew[8*b +: 8] = exp_p[4 * (n / 4) + b];
        rdchk($sformatf("R6 prio irq%0d val %0h", n, v), 8'h20 + 8'(4 * (n / 4)), ew);
      end
    end
    wr(8'h20, 0); wr(8'h24, 0);

    // R2 / R9
    wr(8'h00, 32'hFF);
    global_mask = 1'b1;
    wr(8'h08, 32'h08);
    rdchk("R2 pend set read", 8'h08, 32'h08);
    rdchk("R2 pend clear addr read", 8'h0C, 32'h08);
    chk("R9 mask blocks", {31'd0, irq_valid}, 0);
    wr(8'h0C, 32'h08);
    global_mask = 1'b0; #1;
    chk("R2 cancelled", {31'd0, irq_valid}, 0);
    global_mask = 1'b1;
    wr(8'h08, 32'h10);
    chk("R9 mask blocks again", {31'd0, irq_valid}, 0);
    global_mask = 1'b0; #1;
    chk("R9 unmask offers", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd4});
    wr(8'h0C, 32'hFF);

    // R3 / R4
    irq_req[2] = 1'b1; tick();
    irq_req[2] = 1'b0; tick();
    rdchk("R3 pending held after drop", 8'h08, 32'h04);
    pulse(2); pulse(2);
    rdchk("R3 pulses merge", 8'h08, 32'h04);
    chk("R7 offer irq2", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd2});
    ack();
    rdchk("R4 ack clears pending", 8'h08, 0);
    rdchk("R4 ack sets active", 8'h10, 32'h04);
    chk("R3 single request", {31'd0, irq_valid}, 0);
    ret();
    rdchk("R4 ret clears active", 8'h10, 0);
    chk("R3 no second entry", {31'd0, irq_valid}, 0);

    // R5
    irq_req[3] = 1'b1; tick();
    ack();
    tick(); tick();
    rdchk("R5 held no repend while active", 8'h08, 0);
    ret();
    rdchk("R5 held repends at return", 8'h08, 32'h08);
    chk("R5 reentry offered", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd3});
    ack();
    irq_req[3] = 1'b0; tick();
    pulse(3);
    rdchk("R5 repend in handler", 8'h08, 32'h08);
    ret();
    rdchk("R5 pending kept", 8'h08, 32'h08);
    ack(); ret();
    rdchk("R5 low at return", 8'h08, 0);
    rdchk("R4 active idle", 8'h10, 0);

    // R8 nesting
    wr(8'h20, 32'h0000C000, 4'b0010);
    wr(8'h24, 32'h00004040, 4'b0011);
    wr(8'h08, 32'h02);
    chk("R8 base offer", {20'd0, irq_valid, irq_id, irq_prio}, {20'd0, 1'b1, 3'd1, 8'hC0});
    ack();
    wr(8'h08, 32'h20);
    chk("R8 preempt", {20'd0, irq_valid, irq_id, irq_prio}, {20'd0, 1'b1, 3'd5, 8'h40});
    ack();
    rdchk("R8 nested active", 8'h10, 32'h22);
    wr(8'h08, 32'h10);
    chk("R8 equal no preempt", {31'd0, irq_valid}, 0);
    ret();
    rdchk("R8 pop newest", 8'h10, 32'h02);
    chk("R8 offer after pop", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd4});
    ack(); ret(); ret();
    rdchk("R8 unwound", 8'h10, 0);
    ret();
    rdchk("R4 empty return", 8'h10, 0);

    // R7 sweep
    for (int p = 0; p < 64; p++) begin
      logic [2:0] pr [N];
      logic [7:0] pm, en, cm;
      logic [31:0] w0, w1;
      int best;
      for (int k = 0; k < N; k++) pr[k] = 3'((p * 3 + k * 5 + (p / 8) * k) % 8);
      w0 = {pr[3], 5'd0, pr[2], 5'd0, pr[1], 5'd0, pr[0], 5'd0};
      w1 = {pr[7], 5'd0, pr[6], 5'd0, pr[5], 5'd0, pr[4], 5'd0};
      wr(8'h20, w0); wr(8'h24, w1);
      pm = 8'((p * 37 + 11) & 255);
      if (pm == 0) pm = 8'h01;
      en = (p >= 32) ? ~(8'h01 << (p % 8)) : 8'hFF;
      wr(8'h04, 32'hFF); wr(8'h00, {24'd0, en});
      wr(8'h08, {24'd0, pm});
      cm = pm & en;
      best = -1;
      for (int k = 0; k < N; k++)
        if (cm[k] && (best < 0 || pr[k] < pr[best])) best = k;
      if (best < 0)
        chk($sformatf("R7 sweep %0d none", p), {31'd0, irq_valid}, 0);
      else
        chk($sformatf("R7 sweep %0d", p), {20'd0, irq_valid, irq_id, irq_prio},
            {20'd0, 1'b1, 3'(best), pr[best], 5'd0});
      wr(8'h0C, 32'hFF);
    end

    // R10 base mask
    wr(8'h00, 32'hFF);
    wr(8'h20, 32'h00000040, 4'b0001);
    wr(8'h08, 32'h01);
    base_mask = 8'h40; #1;
    chk("R10 equal blocked", {31'd0, irq_valid}, 0);
    base_mask = 8'h20; #1;
    chk("R10 greater blocked", {31'd0, irq_valid}, 0);
    base_mask = 8'h41; #1;
    chk("R10 below passes", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd0});
    base_mask = 8'h00; #1;
    chk("R10 zero disables", {28'd0, irq_valid, irq_id}, {28'd0, 1'b1, 3'd0});
    wr(8'h0C, 32'hFF);

    // R11 software trigger
    wr(8'h40, 32'd6);
    rdchk("R11 trigger sets", 8'h08, 32'h40);
    wr(8'h40, 32'd9);
    rdchk("R11 out of range 9", 8'h08, 32'h40);
    wr(8'h40, 32'd8);
    rdchk("R11 out of range 8", 8'h08, 32'h40);
    wr(8'h0C, 32'hFF);

    finish_run();
  end
endmodule